// File: doc/BRIEF.md
# Delayed-Branch Fetch Address Sequencer

This block computes the fetch address, one per cycle, for a single-issue pipeline whose instruction set has one architectural branch delay slot. The instruction at `fetch_addr` is decoded in the same cycle, and its branch fields arrive on the `br_*` inputs. When a branch is taken, the sequencer does not flush the instruction that follows it. It fetches the next sequential word, marks that word as the delay slot with `in_slot`, and moves to the stored target only on the cycle after the slot.

Four branch flavours are resolved:
- a pc-relative jump;
- a pc-relative branch that also links;
- a register-indirect jump;
- a register-indirect branch that links to a second register.

There is also a compare-immediate branch that is taken only when its comparison is false. A linking branch raises a link-write request in its own cycle. The request carries the register index and a return address that skips the delay slot.

A branch found inside a delay slot is illegal. The sequencer flags it on `slot_err` and otherwise ignores it. The reset input is asserted asynchronously and released synchronously. Reset places the sequencer at a parameterised vector, and the first instruction after reset is never a delay slot.

Top module: `dsq_fetch_seq`

## Requirements
- R1: While reset is active, and on the first cycle after its synchronised release, `fetch_addr` equals RESET_VEC (default 0x1000) and `in_slot` is 0. Any pending branch target is dropped.
- R2: An instruction that is not a branch advances `fetch_addr` by 4 on the next cycle. Non-branch kinds are `br_kind` codes 0, 6 and 7.
- R3: A taken branch at address A makes the next cycle fetch A+4 with `in_slot`=1. The cycle after that fetches the branch target with `in_slot`=0.
- R4: For `br_kind` 1 (jump) and 2 (jump and link), the target is A + `br_disp`, with bits [1:0] cleared.
- R5: For `br_kind` 3 (register jump) and 4 (register jump and far link), the target is base + `br_disp` with bits [1:0] cleared. The base is `br_rs_val`, or zero when `br_rs_idx` is 0.
- R6: `br_kind` 2 asserts `lnk_we` in its own cycle, with `lnk_idx`=2 and `lnk_data`=A+8.
- R7: `br_kind` 4 asserts `lnk_we` in its own cycle, with `lnk_idx`=31 and `lnk_data`=A+8.
- R8: `br_kind` 5 compares `br_imm` against the base value using the relation selected by `br_rel`:
  - 0: imm == value
  - 1: imm < value, signed
  - 2: imm < value, unsigned
  - 3: imm <= value, signed

  The branch is taken, to A + `br_disp`, only when the relation is false. Otherwise the instruction behaves as a non-branch.
- R9: A branch kind (codes 1 to 5) presented while `in_slot`=1 drives `slot_err`=1 in that cycle. It writes no link register and does not change the path: the pending target is fetched next.
- R10: `lnk_we` is 0 for every instruction except a linking branch outside a delay slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronised release |
| br_kind | input | 3 | Branch kind of the instruction at `fetch_addr` (codes in R2, R4, R5, R8) |
| br_rel | input | 2 | Compare relation for kind 5 |
| br_rs_idx | input | 5 | Index of the register read for base or compare |
| br_rs_val | input | XLEN | Value of that register from the register file |
| br_imm | input | XLEN | Sign-extended compare immediate |
| br_disp | input | XLEN | Byte displacement, two's complement |
| fetch_addr | output | XLEN | Address of the instruction fetched this cycle |
| in_slot | output | 1 | Instruction at `fetch_addr` is a delay slot |
| lnk_we | output | 1 | Link-register write request |
| lnk_idx | output | 5 | Link destination register |
| lnk_data | output | XLEN | Return address |
| slot_err | output | 1 | Illegal branch inside a delay slot |

## Verification
The sequencer's state is the fetch address, a one-bit pending flag and a stored target. A fault in the pending flag shows within one cycle, either as a missing or stuck `in_slot` or as a target fetched one instruction too early or too late. A wrong stored target is first seen at `fetch_addr` exactly two cycles after the taken branch. A branch in a slot that is not ignored is seen through an unexpected link write in the same cycle, or a diverted address on the next one. The bench walks a program trace through every kind and relation, each relation both true and false. It then resets in the middle of a pending branch.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

  // Branch kinds decoded upstream. Codes 6 and 7 are treated as non-branch.
  typedef enum logic [2:0] {
    BK_NONE     = 3'd0,
    BK_REL      = 3'd1,
    BK_REL_LINK = 3'd2,
    BK_REG      = 3'd3,
    BK_REG_LINK = 3'd4,
    BK_CMPF     = 3'd5
  } br_kind_e;

  // Relation evaluated as (imm REL value) by the compare-branch.
  typedef enum logic [1:0] {
    CR_EQ  = 2'd0,
    CR_SLT = 2'd1,
    CR_ULT = 2'd2,
    CR_SLE = 2'd3
  } cmp_rel_e;

  function automatic logic kind_is_branch(input logic [2:0] k);
    return (k >= 3'd1) && (k <= 3'd5);
  endfunction

  function automatic logic kind_is_reg(input logic [2:0] k);
    return (k == BK_REG) || (k == BK_REG_LINK);
  endfunction

endpackage

// File: rtl/dsq_rst_sync.sv
module dsq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dsq_cmp_eval.sv
module dsq_cmp_eval #(
  parameter int XLEN = 32
) (
  input  logic [1:0]      rel,
  input  logic [XLEN-1:0] imm,
  input  logic [XLEN-1:0] value,
  output logic            rel_true
);
  import dsq_pkg::*;

  logic eq, slt, ult;

  always_comb begin
    eq  = (imm == value);
    slt = ($signed(imm) < $signed(value));
    ult = (imm < value);
    case (cmp_rel_e'(rel))
      CR_EQ:   rel_true = eq;
      CR_SLT:  rel_true = slt;
      CR_ULT:  rel_true = ult;
      default: rel_true = slt | eq;
    endcase
  end
endmodule

// File: rtl/dsq_target_gen.sv
module dsq_target_gen #(
  parameter int XLEN       = 32,
  parameter int IDX_W      = 5,
  parameter int ALIGN_BITS = 2
) (
  input  logic [2:0]      kind,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] disp,
  input  logic [IDX_W-1:0] rs_idx,
  input  logic [XLEN-1:0] rs_val,
  output logic [XLEN-1:0] base_val,
  output logic [XLEN-1:0] target
);
  import dsq_pkg::*;

  logic [XLEN-1:0] raw;

  // Register zero always reads as zero.
  assign base_val = (rs_idx == '0) ? '0 : rs_val;

  always_comb begin
    if (kind_is_reg(kind)) raw = base_val + disp;
    else                   raw = pc + disp;
  end

  generate
    if (ALIGN_BITS > 0) begin : g_align
      assign target = {raw[XLEN-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    end else begin : g_noalign
      assign target = raw;
    end
  endgenerate
endmodule

// File: rtl/dsq_link_gen.sv
module dsq_link_gen #(
  parameter int XLEN      = 32,
  parameter int IDX_W     = 5,
  parameter int LINK_NEAR = 2,
  parameter int LINK_FAR  = 31,
  parameter int RET_OFS   = 8
) (
  input  logic [2:0]       kind,
  input  logic             active,
  input  logic [XLEN-1:0]  pc,
  output logic             we,
  output logic [IDX_W-1:0] idx,
  output logic [XLEN-1:0]  data
);
  import dsq_pkg::*;

  // A link aimed at register zero would be discarded, so it is never raised.
  localparam bit NEAR_EN = (LINK_NEAR != 0);
  localparam bit FAR_EN  = (LINK_FAR != 0);

  logic near_hit, far_hit;

  always_comb begin
    near_hit = active && (kind == BK_REL_LINK) && NEAR_EN;
    far_hit  = active && (kind == BK_REG_LINK) && FAR_EN;
    we       = near_hit || far_hit;
    idx      = far_hit ? IDX_W'(LINK_FAR) : IDX_W'(LINK_NEAR);
    data     = pc + XLEN'(RET_OFS);
  end
endmodule

// File: rtl/dsq_fetch_seq.sv
module dsq_fetch_seq #(
  parameter int              XLEN        = 32,
  parameter int              REG_IDX_W   = 5,
  parameter int              INSTR_BYTES = 4,
  parameter logic [XLEN-1:0] RESET_VEC   = 32'h0000_1000,
  parameter int              LINK_NEAR   = 2,
  parameter int              LINK_FAR    = 31,
  parameter int              RST_STAGES  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           br_kind,
  input  logic [1:0]           br_rel,
  input  logic [REG_IDX_W-1:0] br_rs_idx,
  input  logic [XLEN-1:0]      br_rs_val,
  input  logic [XLEN-1:0]      br_imm,
  input  logic [XLEN-1:0]      br_disp,
  output logic [XLEN-1:0]      fetch_addr,
  output logic                 in_slot,
  output logic                 lnk_we,
  output logic [REG_IDX_W-1:0] lnk_idx,
  output logic [XLEN-1:0]      lnk_data,
  output logic                 slot_err
);
  import dsq_pkg::*;

  localparam int ALIGN_BITS = $clog2(INSTR_BYTES);
  localparam int RET_OFS    = 2 * INSTR_BYTES;
  localparam logic [XLEN-1:0] STEP = XLEN'(INSTR_BYTES);

  logic            rst_sync_n;
  logic [XLEN-1:0] pc_q, pc_d;
  logic            pend_q, pend_d;
  logic [XLEN-1:0] tgt_q, tgt_d;
  logic            tgt_en;
  logic            is_br, br_act, rel_true, take_br;
  logic [XLEN-1:0] base_val, target;

  dsq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dsq_target_gen #(.XLEN(XLEN), .IDX_W(REG_IDX_W), .ALIGN_BITS(ALIGN_BITS)) u_tgt (
    .kind     (br_kind),
    .pc       (pc_q),
    .disp     (br_disp),
    .rs_idx   (br_rs_idx),
    .rs_val   (br_rs_val),
    .base_val (base_val),
    .target   (target)
  );

  dsq_cmp_eval #(.XLEN(XLEN)) u_cmp (
    .rel      (br_rel),
    .imm      (br_imm),
    .value    (base_val),
    .rel_true (rel_true)
  );

  dsq_link_gen #(
    .XLEN(XLEN), .IDX_W(REG_IDX_W), .LINK_NEAR(LINK_NEAR),
    .LINK_FAR(LINK_FAR), .RET_OFS(RET_OFS)
  ) u_lnk (
    .kind   (br_kind),
    .active (br_act),
    .pc     (pc_q),
    .we     (lnk_we),
    .idx    (lnk_idx),
    .data   (lnk_data)
  );

  // Branch resolution: a branch inside a slot is flagged and never acts.
  always_comb begin
    is_br    = kind_is_branch(br_kind);
    br_act   = is_br && !pend_q;
    slot_err = is_br && pend_q;
    take_br  = br_act && ((br_kind != BK_CMPF) || !rel_true);
  end

  // Next-state: the slot always follows sequentially; the target comes after it.
  always_comb begin
    pc_d   = pend_q ? tgt_q : (pc_q + STEP);
    pend_d = take_br;
    tgt_en = take_br;
    tgt_d  = target;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q   <= RESET_VEC;
      pend_q <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  tgt_q <= '0;
    else if (tgt_en)  tgt_q <= tgt_d;
  end

  assign fetch_addr = pc_q;
  assign in_slot    = pend_q;
endmodule

// File: rtl/dsq_fetch_seq_chk.sv
module dsq_fetch_seq_chk #(
  parameter int              XLEN        = 32,
  parameter int              REG_IDX_W   = 5,
  parameter int              INSTR_BYTES = 4,
  parameter logic [XLEN-1:0] RESET_VEC   = 32'h0000_1000,
  parameter int              LINK_NEAR   = 2,
  parameter int              LINK_FAR    = 31
) (
  input logic                 clk,
  input logic                 rst_sync_n,
  input logic [XLEN-1:0]      fetch_addr,
  input logic                 in_slot,
  input logic                 take_br,
  input logic                 lnk_we,
  input logic [REG_IDX_W-1:0] lnk_idx,
  input logic [XLEN-1:0]      lnk_data,
  input logic                 slot_err
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSTR_BYTES);

  logic seen_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) seen_q <= 1'b0;
    else             seen_q <= 1'b1;
  end

  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !seen_q |-> (fetch_addr == RESET_VEC) && !in_slot);

  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!in_slot && !take_br) |=> (fetch_addr == $past(fetch_addr) + STEP) && !in_slot);

  p_slot_next_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    take_br |=> in_slot && (fetch_addr == $past(fetch_addr) + STEP));

  p_slot_single_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_slot |=> !in_slot);

  p_word_align_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fetch_addr[1:0] == 2'b00);

  p_link_ret_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lnk_we |-> (lnk_data == fetch_addr + 2 * STEP) && !in_slot);

  p_link_idx_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lnk_we |-> (lnk_idx == REG_IDX_W'(LINK_NEAR)) || (lnk_idx == REG_IDX_W'(LINK_FAR)));

  p_slot_err_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    slot_err |-> in_slot && !lnk_we && !take_br);
endmodule

bind dsq_fetch_seq dsq_fetch_seq_chk #(
  .XLEN(XLEN), .REG_IDX_W(REG_IDX_W), .INSTR_BYTES(INSTR_BYTES),
  .RESET_VEC(RESET_VEC), .LINK_NEAR(LINK_NEAR), .LINK_FAR(LINK_FAR)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .fetch_addr (fetch_addr),
  .in_slot    (in_slot),
  .take_br    (take_br),
  .lnk_we     (lnk_we),
  .lnk_idx    (lnk_idx),
  .lnk_data   (lnk_data),
  .slot_err   (slot_err)
);

// File: tb/dsq_fetch_seq_test.sv
`timescale 1ns/1ps
module dsq_fetch_seq_test;
  typedef struct packed {
    logic [3:0]  rq;
    logic [2:0]  kind;
    logic [1:0]  rel;
    logic [4:0]  ridx;
    logic [31:0] rval;
    logic [31:0] imm;
    logic [31:0] disp;
    logic [31:0] pc;
    logic        slot;
    logic        we;
    logic [4:0]  idx;
    logic [31:0] ld;
    logic        err;
  } vec_t;

  localparam int NV = 23;
  // rq names the requirement that decides the expected fetch address.
  localparam vec_t VEC [NV] = '{
    '{4'd1,  3'd0, 2'd0, 5'd0, 32'h0,        32'h0,        32'h0,        32'h1000, 1'b0, 1'b0, 5'd0,  32'h0,    1'b0},
    '{4'd2,  3'd0, 2'd0, 5'd0, 32'h0,        32'h0,        32'h0,        32'h1004, 1'b0, 1'b0, 5'd0,  32'h0,    1'b0},
    '{4'd2,  3'd1, 2'd0, 5'd0, 32'h0,        32'h0,        32'h100,      32'h1008, 1'b0, 1'b0, 5'd0,  32'h0,    1'b0},
    '{4'd3,  3'd0, 2'd0, 5'd0, 32'h0,        32'h0,        32'h0,        32'h100C, 1'b1, 1'b0, 5'd0,  32'h0,    1'b0},
    '{4'd4,  3'd0, 2'd0, 5'd0, 32'h0,        32'h0,        32'h0,        32'h1108, 1'b0, 1'b0, 5'd0,  32'h0,    1'b0},
    '{4'd4,  3'd2, 2'd0, 5'd0, 32'h0,        32'h0,        32'hFFFFFF03, 32'h110C, 1'b0, 1'b1, 5'd2,  32'h1114, 1'b0},
    '{4'd3,  3'd1, 2'd0, 5'd0, 32'h0,        32'h0,        32'h40,       32'h1110, 1'b1, 1'b0, 5'd0,  32'h0,    1'b1},
    '{4'd4,  3'd0, 2'd0, 5'd0, 32'h0,        32'h0,        32'h0,        32'h100C, 1'b0, 1'b0, 5'd0,  32'h0,    1'b0},
    '{4'd2,  3'd3, 2'd0, 5'd5, 32'h2003,     32'h0,        32'h10,       32'h1010, 1'b0, 1'b0, 5'd0,  32'h0,    1'b0},
    '{4'd3,  3'd0, 2'd0, 5'd0, 32'h0,        32'h0,        32'h0,        32'h1014, 1'b1, 1'b0, 5'd0,  32'h0,    1'b0},
    '{4'd5,  3'd4, 2'd0, 5'd0, 32'hDEADBEEF, 32'h0,        32'h300,      32'h2010, 1'b0, 1'b1, 5'd31, 32'h2018, 1'b0},
    '{4'd3,  3'd0, 2'd0, 5'd0, 32'h0,        32'h0,        32'h0,        32'h2014, 1'b1, 1'b0, 5'd0,  32'h0,    1'b0},
    '{4'd5,  3'd5, 2'd0, 5'd3, 32'h5,        32'h5,        32'h40,       32'h0300, 1'b0, 1'b0, 5'd0,  32'h0,    1'b0},
    '{4'd8,  3'd5, 2'd0, 5'd3, 32'h6,        32'h5,        32'h40,       32'h0304, 1'b0, 1'b0, 5'd0,  32'h0,    1'b0},
    '{4'd3,  3'd0, 2'd0, 5'd0, 32'h0,        32'h0,        32'h0,        32'h0308, 1'b1, 1'b0, 5'd0,  32'h0,    1'b0},
    '{4'd8,  3'd5, 2'd1, 5'd4, 32'h1,        32'hFFFFFFFF, 32'h40,       32'h0344, 1'b0, 1'b0, 5'd0,  32'h0,    1'b0},
    '{4'd8,  3'd5, 2'd2, 5'd4, 32'h1,        32'hFFFFFFFF, 32'h20,       32'h0348, 1'b0, 1'b0, 5'd0,  32'h0,    1'b0},
    '{4'd3,  3'd2, 2'd0, 5'd0, 32'h0,        32'h0,        32'h80,       32'h034C, 1'b1, 1'b0, 5'd0,  32'h0,    1'b1},
    '{4'd8,  3'd5, 2'd3, 5'd6, 32'h7,        32'h7,        32'h40,       32'h0368, 1'b0, 1'b0, 5'd0,  32'h0,    1'b0},
    '{4'd8,  3'd5, 2'd3, 5'd6, 32'h7,        32'h8,        32'hFFFFFFFC, 32'h036C, 1'b0, 1'b0, 5'd0,  32'h0,    1'b0},
    '{4'd3,  3'd7, 2'd0, 5'd0, 32'h0,        32'h0,        32'h100,      32'h0370, 1'b1, 1'b0, 5'd0,  32'h0,    1'b0},
    '{4'd8,  3'd6, 2'd0, 5'd0, 32'h0,        32'h0,        32'h100,      32'h0368, 1'b0, 1'b0, 5'd0,  32'h0,    1'b0},
    '{4'd2,  3'd0, 2'd0, 5'd0, 32'h0,        32'h0,        32'h0,        32'h036C, 1'b0, 1'b0, 5'd0,  32'h0,    1'b0}
  };

  logic        clk;
  logic        rst_n;
  logic [2:0]  br_kind;
  logic [1:0]  br_rel;
  logic [4:0]  br_rs_idx;
  logic [31:0] br_rs_val, br_imm, br_disp;
  logic [31:0] fetch_addr, lnk_data;
  logic        in_slot, lnk_we, slot_err;
  logic [4:0]  lnk_idx;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  dsq_fetch_seq uut (
    .clk(clk), .rst_n(rst_n), .br_kind(br_kind), .br_rel(br_rel),
    .br_rs_idx(br_rs_idx), .br_rs_val(br_rs_val), .br_imm(br_imm), .br_disp(br_disp),
    .fetch_addr(fetch_addr), .in_slot(in_slot), .lnk_we(lnk_we), .lnk_idx(lnk_idx),
    .lnk_data(lnk_data), .slot_err(slot_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic string rtag(input logic [3:0] n);
    case (n)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd8:    return "R8";
      default: return "R?";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic drive_idle();
    br_kind = 3'd0; br_rel = 2'd0; br_rs_idx = 5'd0;
    br_rs_val = 32'h0; br_imm = 32'h0; br_disp = 32'h0;
  endtask

  // Release reset at a falling edge; internal release takes two rising edges.
  task automatic release_reset();
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    drive_idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    #2;
    chk("R1", "fetch_addr in reset", fetch_addr, 32'h1000);
    chk("R1", "in_slot in reset", {31'b0, in_slot}, 32'h0);
    release_reset();

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      br_kind = VEC[i].kind; br_rel = VEC[i].rel; br_rs_idx = VEC[i].ridx;
      br_rs_val = VEC[i].rval; br_imm = VEC[i].imm; br_disp = VEC[i].disp;
      #2;
      chk(rtag(VEC[i].rq), $sformatf("vec %0d fetch_addr", i), fetch_addr, VEC[i].pc);
      chk("R3", $sformatf("vec %0d in_slot", i), {31'b0, in_slot}, {31'b0, VEC[i].slot});
      chk("R9", $sformatf("vec %0d slot_err", i), {31'b0, slot_err}, {31'b0, VEC[i].err});
      if (VEC[i].we) begin
        chk((VEC[i].idx == 5'd2) ? "R6" : "R7", $sformatf("vec %0d lnk_we", i), {31'b0, lnk_we}, 32'h1);
        chk((VEC[i].idx == 5'd2) ? "R6" : "R7", $sformatf("vec %0d lnk_idx", i), {27'b0, lnk_idx}, {27'b0, VEC[i].idx});
        chk((VEC[i].idx == 5'd2) ? "R6" : "R7", $sformatf("vec %0d lnk_data", i), lnk_data, VEC[i].ld);
      end else begin
        chk("R10", $sformatf("vec %0d lnk_we", i), {31'b0, lnk_we}, 32'h0);
      end
    end

    // Directed: reset while a branch target is pending drops it (R1).
    @(negedge clk);
    drive_idle();
    br_kind = 3'd1; br_disp = 32'h400;      // taken jump at 0x370
    #2;
    chk("R3", "pre-reset branch addr", fetch_addr, 32'h0370);
    @(negedge clk);
    drive_idle();
    #2;
    chk("R3", "pre-reset slot", {31'b0, in_slot}, 32'h1);
    rst_n = 1'b0;
    #2;
    chk("R1", "async reset fetch_addr", fetch_addr, 32'h1000);
    chk("R1", "async reset in_slot", {31'b0, in_slot}, 32'h0);
    release_reset();
    @(negedge clk);
    #2;
    chk("R1", "first after release fetch_addr", fetch_addr, 32'h1000);
    chk("R1", "first after release in_slot", {31'b0, in_slot}, 32'h0);
    @(negedge clk);
    #2;
    chk("R1", "pending target discarded", fetch_addr, 32'h1004);
    chk("R1", "no slot after reset", {31'b0, in_slot}, 32'h0);

    // Directed: register jump with a misaligned base of an indexed register (R5).
    @(negedge clk);
    br_kind = 3'd3; br_rs_idx = 5'd9; br_rs_val = 32'h4001; br_disp = 32'h2;
    #2;
    chk("R5", "reg jump addr", fetch_addr, 32'h1008);
    @(negedge clk);
    drive_idle();
    #2;
    chk("R3", "reg jump slot", fetch_addr, 32'h100C);
    @(negedge clk);
    #2;
    chk("R5", "reg jump aligned target", fetch_addr, 32'h4000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule